// File: doc/BRIEF.md
# Interrupt Vector Fetch Sequencer

This block turns an accepted interrupt into a new program counter. It keeps a 16-bit vector base register, which a set-vector-base command loads. The low four bits of that register are always zero, so the base is always a multiple of 16. When an interrupt line is accepted, the sequencer first pushes the caller's return address into the return stack, the same way a subroutine call does. It then reads the two-byte handler address for that line from a byte-wide memory and presents the result as the new program counter, together with a one-cycle strobe.

The handler table starts at the base. Each line has a 16-bit entry, with entries two bytes apart and ordered from the lowest-priority line upward. The high byte of an entry sits at the lower address. Choosing which line to accept, latching pending requests and storing the stack all belong to neighbouring blocks.

The request, push and memory interfaces are valid/ready. A request is taken only in a cycle where `req_valid` and `req_ready` are both high, and `req_ready` is high only while the sequencer is idle. A push completes in a cycle where `push_valid` and `push_ready` are both high. A memory read completes in a cycle where `mem_req` and `mem_ready` are both high, and `mem_rdata` is sampled in that same cycle. While the far side holds its ready low, the sequencer keeps its valid or request high and keeps its data and address unchanged.

Top module: `ivf_vector_seq`

## Requirements
- R1: One cycle after `base_wr` is high, `base_q` equals `base_wdata` with bits 3:0 forced to zero, whatever value those bits were written with.
- R2: While reset is asserted, and right after it, `base_q` is zero, `busy` is low, `req_ready` is high, and `push_valid`, `mem_req` and `pc_valid` are low. A reset in the middle of a sequence abandons that sequence.
- R3: For line n, the first read goes to address base + 2n and the second read goes to base + 2n + 1. Line 0 reads at base + 0 and line 7 reads at base + 14.
- R4: `pc_out` equals {first byte read, second byte read}, so the entry is taken big-endian. `pc_valid` is high for exactly one cycle, the cycle after the second read completes.
- R5: The sequence goes idle, push, high read, low read, done. `push_data` carries the return address given with the request, and no memory read starts before the push has completed.
- R6: Back-pressure: while `push_ready` is low, `push_valid` stays high and `push_data` stays unchanged. While `mem_ready` is low, `mem_req` stays high and `mem_addr` stays unchanged.
- R7: `busy` is high from the cycle after acceptance up to and including the done cycle, and `req_ready` is low during all of that time. A request presented while the sequencer is busy is ignored: it changes neither the addresses read nor the result, and it starts no second sequence.
- R8: The table address is fixed when a request is accepted. A base write during a sequence updates `base_q` but leaves the reads of that sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_wr | input | 1 | Set-vector-base command |
| base_wdata | input | 16 | Value to load into the base register |
| base_q | output | 16 | Current vector base, bits 3:0 always zero |
| req_valid | input | 1 | Interrupt accept request |
| req_line | input | 3 | Index of the accepted line, 0 = lowest priority |
| req_ret | input | 16 | Return address to push |
| req_ready | output | 1 | High while idle; a request is taken when this and req_valid are both high |
| busy | output | 1 | A sequence is in progress |
| push_valid | output | 1 | Return-stack push request |
| push_data | output | 16 | Return address being pushed |
| push_ready | input | 1 | Stack accepts the push |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Byte address being read |
| mem_rdata | input | 8 | Read data, valid when mem_ready is high |
| mem_ready | input | 1 | Memory completes the read this cycle |
| pc_valid | output | 1 | One-cycle strobe: pc_out holds the handler address |
| pc_out | output | 16 | Assembled handler address |

## Verification
The bench writes base values with non-zero low nibbles. A design that failed to force those bits to zero would read from a misaligned table. It also drives the lines at both ends of the table, including a base of 0xFFF0 with line 7, where the low byte lands at 0xFFFF. A swapped byte order or a stride of one byte would give the wrong handler there. The push and read handshakes are stalled by varying amounts, to show that a design that advanced without a handshake would lose or misorder bytes. Finally, the bench presents a second request while the sequencer is busy, writes the base during a fetch, and resets in the middle of a sequence. A design that took the second request, re-read the base mid-sequence, or kept running through reset would show the wrong addresses, an extra strobe, or a non-zero state after reset.

// File: rtl/ivf_pkg.sv
package ivf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PUSH    = 3'd1,
    ST_READ_HI = 3'd2,
    ST_READ_LO = 3'd3,
    ST_DONE    = 3'd4
  } ivf_state_e;
endpackage

// File: rtl/ivf_base_reg.sv
module ivf_base_reg #(
  parameter int ADDR_W     = 16,
  parameter int ALIGN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] base_q
);
  localparam int HI_W = ADDR_W - ALIGN_BITS;

  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (wr_en) hi_q <= wr_data[ADDR_W-1:ALIGN_BITS];
  end

  assign base_q = {hi_q, {ALIGN_BITS{1'b0}}};

  AST_BASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> base_q == {$past(wr_data[ADDR_W-1:ALIGN_BITS]), {ALIGN_BITS{1'b0}}}); // R1
  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(base_q)); // R1
endmodule

// File: rtl/ivf_entry_addr.sv
module ivf_entry_addr #(
  parameter int ADDR_W = 16,
  parameter int LINE_W = 3
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [LINE_W-1:0] line,
  output logic [ADDR_W-1:0] entry
);
  localparam int PAD_W = ADDR_W - LINE_W - 1;

  logic [ADDR_W-1:0] offset;

  assign offset = {{PAD_W{1'b0}}, line, 1'b0};
  assign entry  = base + offset;
endmodule

// File: rtl/ivf_fsm.sv
module ivf_fsm
  import ivf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic push_ready,
  input  logic mem_ready,
  output logic req_ready,
  output logic busy,
  output logic push_valid,
  output logic mem_req,
  output logic lo_sel,
  output logic accept,
  output logic hi_take,
  output logic lo_take,
  output logic pc_valid
);
  ivf_state_e state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d    = state_q;
    req_ready  = 1'b0;
    push_valid = 1'b0;
    mem_req    = 1'b0;
    lo_sel     = 1'b0;
    pc_valid   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) state_d = ST_PUSH;
      end
      ST_PUSH: begin
        push_valid = 1'b1;
        if (push_ready) state_d = ST_READ_HI;
      end
      ST_READ_HI: begin
        mem_req = 1'b1;
        if (mem_ready) state_d = ST_READ_LO;
      end
      ST_READ_LO: begin
        mem_req = 1'b1;
        lo_sel  = 1'b1;
        if (mem_ready) state_d = ST_DONE;
      end
      ST_DONE: begin
        pc_valid = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign busy    = (state_q != ST_IDLE);
  assign accept  = req_ready & req_valid;
  assign hi_take = mem_req & mem_ready & ~lo_sel;
  assign lo_take = mem_req & mem_ready & lo_sel;

  AST_PUSH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(push_valid && push_ready)); // R5
  AST_PUSH_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=> push_valid); // R6
  AST_READ_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> mem_req); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pc_valid |=> !pc_valid && !busy); // R4
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R7
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && push_valid); // R7
endmodule

// File: rtl/ivf_vector_seq.sv
module ivf_vector_seq #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int LINES      = 8,
  parameter int ALIGN_BITS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     base_wr,
  input  logic [ADDR_W-1:0]        base_wdata,
  output logic [ADDR_W-1:0]        base_q,
  input  logic                     req_valid,
  input  logic [$clog2(LINES)-1:0] req_line,
  input  logic [ADDR_W-1:0]        req_ret,
  output logic                     req_ready,
  output logic                     busy,
  output logic                     push_valid,
  output logic [ADDR_W-1:0]        push_data,
  input  logic                     push_ready,
  output logic                     mem_req,
  output logic [ADDR_W-1:0]        mem_addr,
  input  logic [DATA_W-1:0]        mem_rdata,
  input  logic                     mem_ready,
  output logic                     pc_valid,
  output logic [ADDR_W-1:0]        pc_out
);
  localparam int LINE_W = $clog2(LINES);

  logic              accept, hi_take, lo_take, lo_sel;
  logic [ADDR_W-1:0] entry_addr;
  logic [ADDR_W-1:0] tab_q, ret_q;
  logic [DATA_W-1:0] hi_q, lo_q;

  ivf_base_reg #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_base (
    .clk(clk), .rst_n(rst_n), .wr_en(base_wr), .wr_data(base_wdata), .base_q(base_q)
  );

  ivf_entry_addr #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_addr (
    .base(base_q), .line(req_line), .entry(entry_addr)
  );

  ivf_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .push_ready(push_ready),
    .mem_ready(mem_ready), .req_ready(req_ready), .busy(busy),
    .push_valid(push_valid), .mem_req(mem_req), .lo_sel(lo_sel),
    .accept(accept), .hi_take(hi_take), .lo_take(lo_take), .pc_valid(pc_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tab_q <= '0;
      ret_q <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
    end else begin
      if (accept) begin
        tab_q <= entry_addr;
        ret_q <= req_ret;
      end
      if (hi_take) hi_q <= mem_rdata;
      if (lo_take) lo_q <= mem_rdata;
    end
  end

  assign push_data = ret_q;
  assign mem_addr  = tab_q | {{(ADDR_W-1){1'b0}}, lo_sel};
  assign pc_out    = {hi_q, lo_q};

  AST_PUSH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=> $stable(push_data)); // R6
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> $stable(mem_addr)); // R6
  AST_LO_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && !mem_addr[0])
      |=> mem_req && mem_addr == ($past(mem_addr) | {{(ADDR_W-1){1'b0}}, 1'b1})); // R3
  AST_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && mem_addr[0])
      |=> pc_valid && pc_out[DATA_W-1:0] == $past(mem_rdata)); // R4
  AST_FIXED_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && !mem_addr[0] && base_wr)
      |=> mem_addr[ADDR_W-1:1] == $past(mem_addr[ADDR_W-1:1])); // R8
endmodule

// File: tb/tb_ivf_vector_seq.sv
`timescale 1ns/1ps
module tb_ivf_vector_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_wr = 1'b0;
  logic [15:0] base_wdata = '0;
  logic [15:0] base_q;
  logic        req_valid = 1'b0;
  logic [2:0]  req_line = '0;
  logic [15:0] req_ret = '0;
  logic        req_ready, busy, push_valid, mem_req, pc_valid;
  logic [15:0] push_data, mem_addr, pc_out;
  logic        push_ready = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic        mem_ready = 1'b0;

  always #4 clk = ~clk;

  ivf_vector_seq dut (
    .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_wdata(base_wdata), .base_q(base_q),
    .req_valid(req_valid), .req_line(req_line), .req_ret(req_ret), .req_ready(req_ready),
    .busy(busy), .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .pc_valid(pc_valid), .pc_out(pc_out)
  );

  int tests = 0;
  int fails = 0;

  // base value written (low nibble deliberately dirty), line, return address
  localparam logic [34:0] VEC [0:7] = '{
    {16'h0000, 3'd0, 16'h0100},
    {16'h1234, 3'd7, 16'h0ABC},
    {16'h800F, 3'd3, 16'hFFFE},
    {16'hFFF0, 3'd7, 16'h1357},
    {16'h4C48, 3'd5, 16'h2468},
    {16'hA5A5, 3'd1, 16'h0001},
    {16'h7FF8, 3'd6, 16'h8000},
    {16'h0ED1, 3'd2, 16'hC0DE}
  };

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  int          push_stall = 0, mem_stall = 0, pcnt = 0, mcnt = 0;
  int          nreads = 0, done_cnt = 0, push_seen = 0;
  logic [15:0] addr_log [0:1];
  logic [15:0] push_log = '0, pc_log = '0;
  bit          order_err = 0;

  always @(negedge clk) begin
    if (push_valid) begin
      if (pcnt >= push_stall) begin
        push_ready = 1'b1; pcnt = 0; push_log = push_data; push_seen++;
        if (nreads != 0) order_err = 1;
      end else begin
        push_ready = 1'b0; pcnt++;
      end
    end else push_ready = 1'b0;
    if (mem_req) begin
      if (push_seen == 0) order_err = 1;
      if (mcnt >= mem_stall) begin
        mem_ready = 1'b1; mem_rdata = mem_byte(mem_addr); mcnt = 0;
        if (nreads < 2) addr_log[nreads] = mem_addr;
        nreads++;
      end else begin
        mem_ready = 1'b0; mcnt++;
      end
    end else mem_ready = 1'b0;
    if (pc_valid) begin
      pc_log = pc_out; done_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_base(input logic [15:0] v);
    @(negedge clk); base_wr = 1'b1; base_wdata = v;
    @(negedge clk); base_wr = 1'b0;
  endtask

  // start one request; intrude presents a second request while busy
  task automatic run_req(input logic [2:0] line, input logic [15:0] ret, input int ps,
                         input int ms, input bit intrude, input logic [15:0] mid_base);
    int start_done;
    push_stall = ps; mem_stall = ms; pcnt = 0; mcnt = 0;
    nreads = 0; push_seen = 0; order_err = 0;
    addr_log[0] = '0; addr_log[1] = '0;
    start_done = done_cnt;
    @(negedge clk); req_valid = 1'b1; req_line = line; req_ret = ret;
    @(negedge clk); req_valid = 1'b0;
    for (int c = 0; c < 80 && done_cnt == start_done; c++) begin
      if (intrude && c < 3) begin
        req_valid = 1'b1; req_line = ~line; req_ret = ~ret;
        if (c == 0) chk(req_ready == 1'b0 && busy == 1'b1, "R7 busy blocks req_ready",
                        {30'd0, busy, req_ready}, 32'h2);
      end else req_valid = 1'b0;
      if (mid_base != 16'h0 && c == 1) begin
        base_wr = 1'b1; base_wdata = mid_base;
      end else base_wr = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0; base_wr = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] bexp, hi_a, exp_pc;
    int d0;
    repeat (3) @(negedge clk);
    // R2 reset state
    chk(base_q == 16'h0 && !busy && req_ready && !push_valid && !mem_req && !pc_valid,
        "R2 reset state", {base_q, 11'd0, busy, req_ready, push_valid, mem_req, pc_valid},
        32'h00000008);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && busy == 1'b0, "R2 idle after reset", {30'd0, req_ready, busy}, 32'h2);

    for (int i = 0; i < 8; i++) begin
      bexp   = VEC[i][34:19] & 16'hFFF0;
      hi_a   = bexp + {12'd0, VEC[i][18:16], 1'b0};
      exp_pc = {mem_byte(hi_a), mem_byte(hi_a | 16'h1)};
      write_base(VEC[i][34:19]);
      chk(base_q == bexp, "R1 base load masks low nibble", {16'd0, base_q}, {16'd0, bexp});
      d0 = done_cnt;
      run_req(VEC[i][18:16], VEC[i][15:0], i % 3, i % 4, 1'b0, 16'h0);
      chk(push_log == VEC[i][15:0] && push_seen == 1, "R5 return address pushed",
          {16'd0, push_log}, {16'd0, VEC[i][15:0]});
      chk(!order_err, "R5 push precedes reads", {31'd0, order_err}, 32'd0);
      chk(addr_log[0] == hi_a, "R3 high byte address", {16'd0, addr_log[0]}, {16'd0, hi_a});
      chk(addr_log[1] == (hi_a | 16'h1) && nreads == 2, "R3 low byte address",
          {16'd0, addr_log[1]}, {16'd0, hi_a | 16'h1});
      chk(pc_log == exp_pc, "R4 R6 big-endian handler under stalls", {16'd0, pc_log}, {16'd0, exp_pc});
      chk(done_cnt == d0 + 1, "R4 single done strobe", done_cnt, d0 + 1);
    end

    // R7: request presented while busy is ignored
    write_base(16'h2000);
    d0 = done_cnt;
    run_req(3'd2, 16'h4444, 2, 3, 1'b1, 16'h0);
    chk(addr_log[0] == 16'h2004 && addr_log[1] == 16'h2005, "R7 second request ignored",
        {addr_log[0], addr_log[1]}, {16'h2004, 16'h2005});
    chk(done_cnt == d0 + 1 && !busy, "R7 no extra sequence", done_cnt, d0 + 1);
    chk(push_log == 16'h4444, "R7 first return address kept", {16'd0, push_log}, 32'h4444);

    // R8: base write during a fetch does not redirect the reads
    write_base(16'h3000);
    run_req(3'd7, 16'h5555, 0, 4, 1'b0, 16'h9ABF);
    chk(addr_log[0] == 16'h300E && addr_log[1] == 16'h300F, "R8 table fixed at accept",
        {addr_log[0], addr_log[1]}, {16'h300E, 16'h300F});
    chk(base_q == 16'h9AB0, "R8 R1 base still updated", {16'd0, base_q}, 32'h9AB0);

    // R2: reset in the middle of a sequence
    mem_stall = 20; push_stall = 0; mcnt = 0; pcnt = 0;
    @(negedge clk); req_valid = 1'b1; req_line = 3'd1; req_ret = 16'h7777;
    @(negedge clk); req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(mem_req == 1'b1, "R2 sequence running before reset", {31'd0, mem_req}, 32'd1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(base_q == 16'h0 && !busy && !mem_req && !push_valid && !pc_valid && req_ready,
        "R2 mid-sequence reset", {base_q, 12'd0, busy, mem_req, push_valid, pc_valid},
        32'h0);
    d0 = done_cnt;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(done_cnt == d0 && !busy, "R2 abandoned sequence gives no strobe", done_cnt, d0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule